// File: doc/BRIEF.md
# Interrupt controller register decoder

This block is the register front end of a priority-arbitrated interrupt controller. It takes 32-bit word accesses from a simple request/ready register port and splits the address space into four windows: per-source priority registers, read-only pending bit words, per-context enable bit words, and a per-context pair of threshold and claim/complete registers. It holds the priority, enable and threshold state itself and drives that state to the arbiter on flat vectors. It also takes the live pending bits and the per-context winning source IDs back from the arbiter.

All four window base addresses and the two context strides are parameters; both strides must be powers of two. The claim register has a side effect. A read of it pulses a claim strobe to the arbiter and returns the ID the arbiter presents in that same cycle. A write to the same address raises a completion strobe that carries the written ID. Every access is answered exactly one cycle after it is presented. Data is little-endian, and all accesses are full 32-bit words.

Top module: `plic_regdec`

## Requirements
- R1: An access whose address has bits [1:0] not equal to zero changes no state, raises no strobe, and a read of such an address returns zero.
- R2: The word at PRIO_BASE + 4*k holds the priority of source k+1, for k+1 < N_SRC. A write keeps only the low PRIO_W bits of the data, and a read returns the stored value.
- R3: The word at PEND_BASE + 4*w reads pend_i[32*w+b] in bit b, for w < ceil(N_SRC/32); bits for sources at or above N_SRC read zero. Writes to this window change no register.
- R4: In the enable window, the context is (offset >> log2(EN_STRIDE)) and the word is (offset mod EN_STRIDE)/4. Bit b of word w controls source 32*w+b of that context (en_o bit ctx*N_SRC+source). Word indices at or above ceil(N_SRC/32) read zero and writes to them are ignored.
- R5: The word at CTX_BASE + c*CTX_STRIDE is the threshold of context c. A write takes effect only when the data is at most N_PRIO; otherwise the old value stays.
- R6: A read of CTX_BASE + c*CTX_STRIDE + 4 raises claim_o[c] for the cycle in which the request is presented. The response data is the value of claim_id_i for context c sampled in that cycle.
- R7: A write to CTX_BASE + c*CTX_STRIDE + 4 raises cmpl_o[c] in the request cycle, with cmpl_id_o equal to the written data, only when that data is below N_SRC; otherwise no strobe rises.
- R8: A read of an address outside all windows returns zero, and a write to one changes no state.
- R9: rsp_ready is high for exactly one cycle, the cycle after each request, and low otherwise. It carries the read data for reads and zero for writes.
- R10: After reset all priorities, enables and thresholds are zero and rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response pulse, one cycle after the request |
| rsp_rdata | output | 32 | Read data returned with rsp_ready |
| pend_i | input | N_SRC | Pending bits from the arbiter |
| claim_id_i | input | N_CTX*ID_W | Winning source ID per context from the arbiter |
| claim_o | output | N_CTX | Claim strobe per context |
| cmpl_o | output | N_CTX | Completion strobe per context |
| cmpl_id_o | output | ID_W | Source ID being completed |
| prio_o | output | N_SRC*PRIO_W | Source priorities, source s at bits s*PRIO_W |
| en_o | output | N_CTX*N_SRC | Enable bits, context c source s at bit c*N_SRC+s |
| thr_o | output | N_CTX*PRIO_W | Threshold per context |

## Verification
The hardest cases to reach are the claim read and the completion write, because their effect is a strobe that lasts only for the request cycle. For the claim read, the returned ID must come from that same cycle. The bench samples the strobes between the input drive and the capturing edge. It also holds a distinct claim ID on each context, so a wrong context select or a late sample shows up as a wrong value. The ignored cases are checked by reading back or observing the state they could have corrupted: misaligned addresses, pending writes, enable words past the source count, thresholds above the level count and completion IDs out of range.

// File: rtl/plic_regdec_pkg.sv
package plic_regdec_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [7:0]  ctx;
        logic [7:0]  word;
        logic [15:0] src;
    } dec_t;

    function automatic int unsigned words_for(int unsigned n);
        return (n + 31) / 32;
    endfunction

    function automatic logic in_window(logic [31:0] a, int unsigned base, int unsigned len);
        return (a >= base) && (a < base + len);
    endfunction

endpackage

// File: rtl/plic_regdec_decode.sv
module plic_regdec_decode
    import plic_regdec_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned N_SRC      = 40,
    parameter int unsigned N_CTX      = 2,
    parameter int unsigned PRIO_BASE  = 32'h0000,
    parameter int unsigned PEND_BASE  = 32'h1000,
    parameter int unsigned EN_BASE    = 32'h2000,
    parameter int unsigned EN_STRIDE  = 32'h80,
    parameter int unsigned CTX_BASE   = 32'h4000,
    parameter int unsigned CTX_STRIDE = 32'h1000
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int unsigned N_WORDS = words_for(N_SRC);
    localparam int unsigned EN_SH   = $clog2(EN_STRIDE);
    localparam int unsigned CTX_SH  = $clog2(CTX_STRIDE);

    logic [31:0] a32;
    logic [31:0] off;
    logic [31:0] low;
    logic [31:0] widx;

    assign a32 = 32'(addr);

    always_comb begin
        dec        = '0;
        dec.region = RG_NONE;
        off        = '0;
        low        = '0;
        widx       = '0;
        if (a32[1:0] == 2'b00) begin
            if (in_window(a32, PRIO_BASE, (N_SRC - 1) * 4)) begin
                off        = a32 - PRIO_BASE;
                dec.region = RG_PRIO;
                dec.src    = 16'((off >> 2) + 1);
            end else if (in_window(a32, PEND_BASE, N_WORDS * 4)) begin
                off        = a32 - PEND_BASE;
                dec.region = RG_PEND;
                dec.word   = 8'(off >> 2);
            end else if (in_window(a32, EN_BASE, N_CTX * EN_STRIDE)) begin
                off  = a32 - EN_BASE;
                low  = off & (EN_STRIDE - 1);
                widx = low >> 2;
                if (widx < N_WORDS) begin
                    dec.region = RG_EN;
                    dec.ctx    = 8'(off >> EN_SH);
                    dec.word   = 8'(widx);
                end
            end else if (in_window(a32, CTX_BASE, N_CTX * CTX_STRIDE)) begin
                off     = a32 - CTX_BASE;
                low     = off & (CTX_STRIDE - 1);
                dec.ctx = 8'(off >> CTX_SH);
                if (low == 32'd0) begin
                    dec.region = RG_THR;
                end else if (low == 32'd4) begin
                    dec.region = RG_CLAIM;
                end
            end
        end
    end

endmodule

// File: rtl/plic_regdec_store.sv
module plic_regdec_store
    import plic_regdec_pkg::*;
#(
    parameter int unsigned N_SRC  = 40,
    parameter int unsigned N_CTX  = 2,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned N_PRIO = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  dec_t                    dec,
    input  logic [31:0]             wdata,
    output logic [N_SRC*PRIO_W-1:0] prio_q,
    output logic [N_CTX*N_SRC-1:0]  en_q,
    output logic [N_CTX*PRIO_W-1:0] thr_q
);
    assign prio_q[PRIO_W-1:0] = '0;

    for (genvar s = 1; s < N_SRC; s++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[s*PRIO_W +: PRIO_W] <= '0;
            end else if (we && dec.region == RG_PRIO && dec.src == 16'(s)) begin
                prio_q[s*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
            end
        end
    end

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        for (genvar s = 0; s < N_SRC; s++) begin : g_en
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q[c*N_SRC + s] <= 1'b0;
                end else if (we && dec.region == RG_EN && dec.ctx == 8'(c)
                             && dec.word == 8'(s / 32)) begin
                    en_q[c*N_SRC + s] <= wdata[s % 32];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q[c*PRIO_W +: PRIO_W] <= '0;
            end else if (we && dec.region == RG_THR && dec.ctx == 8'(c)
                         && wdata <= 32'(N_PRIO)) begin
                thr_q[c*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
            end
        end

        assert_thr_bound_R5: assert property (@(posedge clk) disable iff (rst)
            32'(thr_q[c*PRIO_W +: PRIO_W]) <= 32'(N_PRIO));
    end

endmodule

// File: rtl/plic_regdec.sv
module plic_regdec
    import plic_regdec_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned N_SRC      = 40,
    parameter int unsigned N_CTX      = 2,
    parameter int unsigned PRIO_W     = 3,
    parameter int unsigned N_PRIO     = 7,
    parameter int unsigned PRIO_BASE  = 32'h0000,
    parameter int unsigned PEND_BASE  = 32'h1000,
    parameter int unsigned EN_BASE    = 32'h2000,
    parameter int unsigned EN_STRIDE  = 32'h80,
    parameter int unsigned CTX_BASE   = 32'h4000,
    parameter int unsigned CTX_STRIDE = 32'h1000,
    localparam int unsigned ID_W      = $clog2(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [31:0]             req_wdata,
    output logic                    rsp_ready,
    output logic [31:0]             rsp_rdata,
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_CTX*ID_W-1:0]   claim_id_i,
    output logic [N_CTX-1:0]        claim_o,
    output logic [N_CTX-1:0]        cmpl_o,
    output logic [ID_W-1:0]         cmpl_id_o,
    output logic [N_SRC*PRIO_W-1:0] prio_o,
    output logic [N_CTX*N_SRC-1:0]  en_o,
    output logic [N_CTX*PRIO_W-1:0] thr_o
);
    localparam int unsigned N_WORDS = words_for(N_SRC);
    localparam int unsigned PAD_W   = N_WORDS * 32;

    dec_t              dec;
    logic [31:0]       rd_c;
    logic [PAD_W-1:0]  pend_pad;

    plic_regdec_decode #(
        .ADDR_W(ADDR_W), .N_SRC(N_SRC), .N_CTX(N_CTX),
        .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
        .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
        .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
    ) u_decode (
        .addr(req_addr),
        .dec (dec)
    );

    plic_regdec_store #(
        .N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W), .N_PRIO(N_PRIO)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (req_valid && req_write),
        .dec   (dec),
        .wdata (req_wdata),
        .prio_q(prio_o),
        .en_q  (en_o),
        .thr_q (thr_o)
    );

    assign pend_pad  = PAD_W'(pend_i);
    assign cmpl_id_o = req_wdata[ID_W-1:0];

    for (genvar c = 0; c < N_CTX; c++) begin : g_strobe
        assign claim_o[c] = req_valid && !req_write && dec.region == RG_CLAIM
                            && dec.ctx == 8'(c);
        assign cmpl_o[c]  = req_valid && req_write && dec.region == RG_CLAIM
                            && dec.ctx == 8'(c) && req_wdata < 32'(N_SRC);
    end

    always_comb begin
        rd_c = '0;
        unique case (dec.region)
            RG_PRIO: begin
                for (int s = 1; s < N_SRC; s++) begin
                    if (dec.src == 16'(s)) rd_c = 32'(prio_o[s*PRIO_W +: PRIO_W]);
                end
            end
            RG_PEND: begin
                for (int w = 0; w < N_WORDS; w++) begin
                    if (dec.word == 8'(w)) rd_c = pend_pad[w*32 +: 32];
                end
            end
            RG_EN: begin
                for (int c = 0; c < N_CTX; c++) begin
                    for (int s = 0; s < N_SRC; s++) begin
                        if (dec.ctx == 8'(c) && dec.word == 8'(s / 32))
                            rd_c[s % 32] = en_o[c*N_SRC + s];
                    end
                end
            end
            RG_THR: begin
                for (int c = 0; c < N_CTX; c++) begin
                    if (dec.ctx == 8'(c)) rd_c = 32'(thr_o[c*PRIO_W +: PRIO_W]);
                end
            end
            RG_CLAIM: begin
                for (int c = 0; c < N_CTX; c++) begin
                    if (dec.ctx == 8'(c)) rd_c = 32'(claim_id_i[c*ID_W +: ID_W]);
                end
            end
            default: rd_c = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ready <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ready <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_c : 32'd0;
        end
    end

    assert_misaligned_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_rdata == 32'd0));

    assert_misaligned_nostrobe_R1: assert property (@(posedge clk) disable iff (rst)
        (req_addr[1:0] != 2'b00) |-> (claim_o == '0 && cmpl_o == '0));

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ready);

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_ready);

    assert_write_data_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == 32'd0));

    assert_claim_read_R6: assert property (@(posedge clk) disable iff (rst)
        (claim_o != '0) |-> (req_valid && !req_write && $onehot0(claim_o)));

    assert_cmpl_write_R7: assert property (@(posedge clk) disable iff (rst)
        (cmpl_o != '0) |-> (req_valid && req_write && req_wdata < 32'(N_SRC)
                            && $onehot0(cmpl_o)));

endmodule

// File: tb/tb_plic_regdec.sv
module tb_plic_regdec;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC  = 40;
    localparam int N_CTX  = 2;
    localparam int PRIO_W = 3;
    localparam int ID_W   = 6;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic                    req_write = 1'b0;
    logic [15:0]             req_addr = '0;
    logic [31:0]             req_wdata = '0;
    logic                    rsp_ready;
    logic [31:0]             rsp_rdata;
    logic [N_SRC-1:0]        pend_i = '0;
    logic [N_CTX*ID_W-1:0]   claim_id_i = '0;
    logic [N_CTX-1:0]        claim_o;
    logic [N_CTX-1:0]        cmpl_o;
    logic [ID_W-1:0]         cmpl_id_o;
    logic [N_SRC*PRIO_W-1:0] prio_o;
    logic [N_CTX*N_SRC-1:0]  en_o;
    logic [N_CTX*PRIO_W-1:0] thr_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plic_regdec dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .pend_i(pend_i), .claim_id_i(claim_id_i),
        .claim_o(claim_o), .cmpl_o(cmpl_o), .cmpl_id_o(cmpl_id_o),
        .prio_o(prio_o), .en_o(en_o), .thr_o(thr_o)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [31:0]      rd;
    logic [N_CTX-1:0] cl, cp;
    logic [ID_W-1:0]  cid;

    task automatic access(input logic w, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        cl = claim_o; cp = cmpl_o; cid = cmpl_id_o;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R9 ready after request", 128'(rsp_ready), 128'(1));
        rd = rsp_rdata;
        if (w) chk("R9 write data zero", 128'(rd), 128'(0));
    endtask

    task automatic t_reset();
        chk("R10 prio reset", 128'(prio_o), 128'(0));
        chk("R10 enable reset", 128'(en_o), 128'(0));
        chk("R10 threshold reset", 128'(thr_o), 128'(0));
        chk("R10 ready reset", 128'(rsp_ready), 128'(0));
    endtask

    task automatic t_priority();
        access(1, 16'h0000, 32'hF);
        chk("R2 src1 masked", 128'(prio_o[1*PRIO_W +: PRIO_W]), 128'(7));
        access(1, 16'h0098, 32'h5);
        chk("R2 src39 write", 128'(prio_o[39*PRIO_W +: PRIO_W]), 128'(5));
        access(0, 16'h0098, 0);
        chk("R2 src39 read", 128'(rd), 128'(5));
        access(0, 16'h0000, 0);
        chk("R2 src1 read", 128'(rd), 128'(7));
        chk("R2 src0 none", 128'(prio_o[0 +: PRIO_W]), 128'(0));
    endtask

    task automatic t_misaligned();
        access(1, 16'h0002, 32'h3);
        chk("R1 misaligned write ignored", 128'(prio_o[1*PRIO_W +: PRIO_W]), 128'(7));
        access(0, 16'h0002, 0);
        chk("R1 misaligned read zero", 128'(rd), 128'(0));
        access(0, 16'h4006, 0);
        chk("R1 misaligned claim no strobe", 128'(cl), 128'(0));
    endtask

    task automatic t_pending();
        logic [N_SRC*PRIO_W-1:0] p;
        pend_i = 40'hA5_1234_5678;
        access(0, 16'h1000, 0);
        chk("R3 pending word0", 128'(rd), 128'(32'h1234_5678));
        access(0, 16'h1004, 0);
        chk("R3 pending word1", 128'(rd), 128'(32'hA5));
        p = prio_o;
        access(1, 16'h1000, 32'hFFFF_FFFF);
        access(0, 16'h1000, 0);
        chk("R3 pending write ignored", 128'(rd), 128'(32'h1234_5678));
        chk("R3 pending write no side effect", 128'(prio_o), 128'(p));
    endtask

    task automatic t_enable();
        access(1, 16'h2084, 32'hFFFF_FFFF);
        chk("R4 ctx1 word1 bits", 128'(en_o), 128'({8'hFF, 72'h0}));
        access(0, 16'h2084, 0);
        chk("R4 ctx1 word1 read", 128'(rd), 128'(32'hFF));
        access(1, 16'h2000, 32'h8000_0001);
        chk("R4 ctx0 word0 bits", 128'(en_o[39:0]), 128'(40'h80_0000_01));
        access(1, 16'h2088, 32'hFFFF_FFFF);
        chk("R4 invalid word ignored", 128'(en_o), 128'({8'hFF, 32'h0, 40'h80_0000_01}));
        access(0, 16'h2088, 0);
        chk("R4 invalid word read zero", 128'(rd), 128'(0));
    endtask

    task automatic t_threshold();
        access(1, 16'h4000, 32'd5);
        chk("R5 thr0 write", 128'(thr_o[0 +: PRIO_W]), 128'(5));
        access(1, 16'h4000, 32'd8);
        chk("R5 thr0 over limit dropped", 128'(thr_o[0 +: PRIO_W]), 128'(5));
        access(1, 16'h5000, 32'd7);
        chk("R5 thr1 at limit", 128'(thr_o[PRIO_W +: PRIO_W]), 128'(7));
        access(0, 16'h4000, 0);
        chk("R5 thr0 read", 128'(rd), 128'(5));
    endtask

    task automatic t_claim();
        claim_id_i = {6'd23, 6'd9};
        access(0, 16'h5004, 0);
        chk("R6 claim strobe ctx1", 128'(cl), 128'(2'b10));
        chk("R6 claim id ctx1", 128'(rd), 128'(23));
        chk("R6 no completion on read", 128'(cp), 128'(0));
        access(0, 16'h4004, 0);
        chk("R6 claim strobe ctx0", 128'(cl), 128'(2'b01));
        chk("R6 claim id ctx0", 128'(rd), 128'(9));
    endtask

    task automatic t_complete();
        access(1, 16'h4004, 32'd17);
        chk("R7 completion strobe", 128'(cp), 128'(2'b01));
        chk("R7 completion id", 128'(cid), 128'(17));
        chk("R7 no claim on write", 128'(cl), 128'(0));
        access(1, 16'h5004, 32'd40);
        chk("R7 out of range dropped", 128'(cp), 128'(0));
    endtask

    task automatic t_unmapped();
        logic [N_SRC*PRIO_W-1:0] p;
        logic [N_CTX*N_SRC-1:0]  e;
        logic [N_CTX*PRIO_W-1:0] t;
        p = prio_o; e = en_o; t = thr_o;
        access(0, 16'h0F00, 0);
        chk("R8 unmapped read zero", 128'(rd), 128'(0));
        access(1, 16'h3000, 32'hFFFF_FFFF);
        access(1, 16'h4008, 32'h1);
        chk("R8 unmapped write prio", 128'(prio_o), 128'(p));
        chk("R8 unmapped write en", 128'(en_o), 128'(e));
        chk("R8 unmapped write thr", 128'(thr_o), 128'(t));
        @(negedge clk);
        chk("R9 ready idle low", 128'(rsp_ready), 128'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_priority();
        t_misaligned();
        t_pending();
        t_enable();
        t_threshold();
        t_claim();
        t_complete();
        t_unmapped();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule